// File: doc/BRIEF.md
# Keyed Debug Register Write Lock

This block protects a small bank of general 32-bit debug registers against stray writes. A simple memory-mapped slave port carries an address, write data, a write strobe and a read strobe, and returns registered read data. Until software writes a 32-bit unlock key to a dedicated key register, every write aimed at the protected bank is dropped. Writing any other value to the key register shuts the bank again.

The lock flag belongs to a separate retention reset domain (`dbg_rst`), so a core reset (`core_rst`) empties the protected registers but keeps the lock state. Software can read back the lock state through a read-only status word. Read data appears one clock after the read strobe. It reflects the state that existed before the edge, so a read and a write in the same cycle return the old value.

Top module: `dbg_wlock_top`

## Requirements
- R1: A write of exactly 0xC5ACCE55 to the key register (byte offset 0x10) clears the lock at that clock edge, and a protected-register write in the very next cycle is accepted.
- R2: A write of any other 32-bit value to the key register sets the lock at that clock edge.
- R3: While the lock is set, writes to the protected registers leave their contents unchanged.
- R4: `dbg_rst` sets the lock and leaves the protected registers unchanged.
- R5: The key register is write-only and reads as 0. It accepts writes whether the bank is locked or unlocked.
- R6: The status word (byte offset 0x14) reads bit 0 = 1, bit 1 = lock (1 locked, 0 writable), bit 2 = 0 and bits 31:3 = 0.
- R7: Writes to the status word, to byte offsets from 0x18 upward, and to addresses whose two low bits are not zero change neither the lock nor any protected register. Reads of those unmapped addresses return 0.
- R8: `core_rst` clears every protected register and the read data to 0 and does not change the lock.
- R9: A read of a protected register returns its stored value in the cycle after the read strobe, whether the bank is locked or not. Cycles without a read strobe return 0.
- R10: Protected register i sits at byte offset 4*i, for i = 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both reset domains |
| core_rst | input | 1 | Synchronous active-high core reset; clears the protected bank |
| dbg_rst | input | 1 | Synchronous active-high retention-domain reset; sets the lock |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |

## Verification
The bench aims at keys that differ from the magic value in a single bit. A design that compares only part of the word would unlock on these keys and take the following bank write. It also sends a bank write in the cycle right after the key write, which catches a lock that clears one cycle late. It pulses `core_rst` while the bank is unlocked and then reads the status word, which exposes a lock flag that was wrongly placed in the core domain. Further cases cover writes to the status word, to offsets past the map and to misaligned addresses, together with a read and a write to the same register in one cycle. A decoder with loose masking, or a read path that shows the new value, would corrupt the bank or the read data in these cases.

// File: rtl/dwl_pkg.sv
package dwl_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;
  typedef enum logic [1:0] {SEL_NONE, SEL_BANK, SEL_KEY, SEL_STAT} sel_e;
endpackage

// File: rtl/dwl_decode.sv
module dwl_decode
  import dwl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NREG   = 4,
  localparam int WORD_W = ADDR_W - 2,
  localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [WORD_W-1:0] KEY_WORD  = WORD_W'(NREG);
  localparam logic [WORD_W-1:0] STAT_WORD = WORD_W'(NREG + 1);

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];
  assign idx  = word[IDX_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      if (word < KEY_WORD)        sel = SEL_BANK;
      else if (word == KEY_WORD)  sel = SEL_KEY;
      else if (word == STAT_WORD) sel = SEL_STAT;
    end
  end
endmodule

// File: rtl/dwl_lock_keeper.sv
module dwl_lock_keeper
  import dwl_pkg::*;
(
  input  logic              clk,
  input  logic              dbg_rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  // Retention domain: only dbg_rst touches this flop.
  always_ff @(posedge clk) begin
    if (dbg_rst)     locked <= 1'b1;
    else if (key_wr) locked <= (wdata != UNLOCK_KEY);
  end
endmodule

// File: rtl/dwl_reg_bank.sv
module dwl_reg_bank
  import dwl_pkg::*;
#(
  parameter int NREG = 4,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                        clk,
  input  logic                        core_rst,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NREG-1:0][DATA_W-1:0] q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (core_rst)                        q[i] <= '0;
      else if (we && idx == IDX_W'(i))     q[i] <= wdata;
    end
  end
endmodule

// File: rtl/dbg_wlock_top.sv
module dbg_wlock_top
  import dwl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              core_rst,
  input  logic              dbg_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  sel_e                        sel;
  logic [IDX_W-1:0]            idx;
  logic                        lock_q;
  logic [NREG-1:0][DATA_W-1:0] bank_q;
  logic [DATA_W-1:0]           stat_word;
  logic [DATA_W-1:0]           rd_mux;

  dwl_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr(bus_addr), .sel(sel), .idx(idx)
  );

  dwl_lock_keeper u_lock (
    .clk(clk), .dbg_rst(dbg_rst),
    .key_wr(bus_wr && sel == SEL_KEY),
    .wdata(bus_wdata), .locked(lock_q)
  );

  dwl_reg_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .core_rst(core_rst),
    .we(bus_wr && sel == SEL_BANK && !lock_q),
    .idx(idx), .wdata(bus_wdata), .q(bank_q)
  );

  always_comb begin
    stat_word    = '0;
    stat_word[0] = 1'b1;
    stat_word[1] = lock_q;
    stat_word[2] = 1'b0;
  end

  always_comb begin
    case (sel)
      SEL_BANK: rd_mux = bank_q[idx];
      SEL_STAT: rd_mux = stat_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (core_rst)    bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/dwl_chk.sv
module dwl_chk
  import dwl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NREG   = 4
) (
  input logic                        clk,
  input logic                        core_rst,
  input logic                        dbg_rst,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [31:0]                 bus_wdata,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [31:0]                 bus_rdata,
  input logic                        locked,
  input logic [NREG-1:0][DATA_W-1:0] bank
);
  localparam logic [ADDR_W-1:0] KEY_ADDR  = ADDR_W'(4 * NREG);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(4 * NREG + 4);

  logic key_hit, bank_hit;
  assign key_hit  = bus_wr && bus_addr == KEY_ADDR;
  assign bank_hit = bus_wr && bus_addr[1:0] == 2'b00 && bus_addr < KEY_ADDR;

  // R1
  key_unlock_chk: assert property (@(posedge clk) disable iff (dbg_rst)
    key_hit && bus_wdata == UNLOCK_KEY |=> !locked);

  // R2
  bad_key_lock_chk: assert property (@(posedge clk) disable iff (dbg_rst)
    key_hit && bus_wdata != UNLOCK_KEY |=> locked);

  // R3
  locked_bank_hold_chk: assert property (@(posedge clk) disable iff (dbg_rst || core_rst)
    locked && !core_rst |=> $stable(bank));

  // R4
  dbg_reset_lock_chk: assert property (@(posedge clk)
    dbg_rst |=> locked);

  // R6
  status_layout_chk: assert property (@(posedge clk) disable iff (core_rst || dbg_rst)
    bus_rd && bus_addr == STAT_ADDR |=> bus_rdata == {29'd0, 1'b0, $past(locked), 1'b1});

  // R8
  core_reset_keeps_lock_chk: assert property (@(posedge clk) disable iff (dbg_rst)
    core_rst && !key_hit |=> $stable(locked));

  // R8
  core_reset_clear_chk: assert property (@(posedge clk)
    core_rst |=> bank == '0 && bus_rdata == 32'd0);

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (core_rst)
    !bus_rd |=> bus_rdata == 32'd0);

  // R7
  nonbank_write_hold_chk: assert property (@(posedge clk) disable iff (dbg_rst || core_rst)
    bus_wr && !bank_hit && !core_rst |=> $stable(bank));
endmodule

bind dbg_wlock_top dwl_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
  .clk(clk), .core_rst(core_rst), .dbg_rst(dbg_rst),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .locked(lock_q), .bank(bank_q)
);

// File: tb/sim_dbg_wlock_top.sv
module sim_dbg_wlock_top;
  localparam int ADDR_W = 6;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;

  logic clk = 1'b0;
  logic core_rst = 1'b1, dbg_rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;

  always #5 clk = ~clk;

  dbg_wlock_top #(.ADDR_W(ADDR_W), .NREG(4)) u0 (
    .clk(clk), .core_rst(core_rst), .dbg_rst(dbg_rst), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  // Reference model state
  bit          m_lock = 1'b1;
  logic [31:0] m_reg [4];
  logic [31:0] m_rd = 32'd0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
    int w = int'(a) / 4;
    if (a % 4 != 0) return 32'd0;
    if (w < 4)  return m_reg[w];
    if (w == 5) return {30'd0, m_lock, 1'b1};
    return 32'd0;
  endfunction

  // One bus cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic cyc(input string tag, input bit wr, input bit rd,
                     input logic [ADDR_W-1:0] a, input logic [31:0] d,
                     input bit crst = 1'b0, input bit drst = 1'b0);
    bit old_lock;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    core_rst = crst; dbg_rst = drst;
    @(posedge clk);
    old_lock = m_lock;
    m_rd = crst ? 32'd0 : (rd ? model_read(a) : 32'd0);
    if (drst) m_lock = 1'b1;
    else if (wr && a == 6'h10) m_lock = (d != KEY);
    if (crst) foreach (m_reg[i]) m_reg[i] = 32'd0;
    else if (wr && !old_lock && a % 4 == 0 && int'(a) / 4 < 4) m_reg[int'(a) / 4] = d;
    @(negedge clk);
    checks++;
    if (bus_rdata !== m_rd) begin
      fails++;
      $display("FAIL %s: rdata actual %h expected %h", tag, bus_rdata, m_rd);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a);
    cyc(tag, 1'b0, 1'b1, a, 32'd0);
  endtask

  initial begin
    foreach (m_reg[i]) m_reg[i] = 32'd0;
    @(negedge clk);
    cyc("R4 reset", 0, 0, 0, 0, 1, 1);
    cyc("R8 reset", 0, 0, 0, 0, 1, 1);
    rd_chk("R6 status after reset", 6'h14);
    cyc("R3 locked write", 1, 0, 6'h00, 32'h1111_1111);
    rd_chk("R3 reg0 unchanged", 6'h00);
    rd_chk("R5 key reads zero", 6'h10);
    cyc("R1 key", 1, 0, 6'h10, KEY);
    cyc("R1 next-cycle write", 1, 0, 6'h04, 32'hA5A5_5A5A);
    rd_chk("R1 reg1 accepted", 6'h04);
    rd_chk("R6 status unlocked", 6'h14);
    for (int i = 0; i < 4; i++)
      cyc("R10 write", 1, 0, ADDR_W'(4 * i), 32'hD000_0000 + 32'(i * 17 + 3));
    for (int i = 0; i < 4; i++) rd_chk("R10 R9 readback", ADDR_W'(4 * i));
    cyc("R7 status write", 1, 0, 6'h14, 32'h0000_0000);
    cyc("R7 unmapped write", 1, 0, 6'h18, 32'hFFFF_FFFF);
    cyc("R7 misaligned write", 1, 0, 6'h02, 32'hBEEF_0000);
    cyc("R7 misaligned key", 1, 0, 6'h11, 32'h0);
    rd_chk("R7 status kept", 6'h14);
    rd_chk("R7 unmapped read", 6'h18);
    for (int i = 0; i < 4; i++) rd_chk("R7 regs kept", ADDR_W'(4 * i));
    cyc("R2 near key", 1, 0, 6'h10, KEY ^ 32'h0000_0001);
    cyc("R3 locked write", 1, 0, 6'h08, 32'h0BAD_0BAD);
    rd_chk("R9 locked read", 6'h08);
    rd_chk("R6 status locked", 6'h14);
    cyc("R2 high-bit miss", 1, 0, 6'h10, KEY ^ 32'h8000_0000);
    cyc("R5 relock while locked", 1, 0, 6'h10, 32'h0);
    cyc("R3 locked write", 1, 0, 6'h0C, 32'h0);
    rd_chk("R3 reg3 kept", 6'h0C);
    cyc("R5 key while locked", 1, 0, 6'h10, KEY);
    cyc("R9 read+write same reg", 1, 1, 6'h0C, 32'h7777_7777);
    rd_chk("R9 new value", 6'h0C);
    cyc("R8 core reset unlocked", 0, 1, 6'h00, 0, 1, 0);
    rd_chk("R8 lock kept", 6'h14);
    for (int i = 0; i < 4; i++) rd_chk("R8 regs cleared", ADDR_W'(4 * i));
    cyc("R8 refill", 1, 0, 6'h04, 32'h1234_5678);
    cyc("R4 dbg reset", 0, 0, 0, 0, 0, 1);
    rd_chk("R4 locked again", 6'h14);
    rd_chk("R4 regs kept", 6'h04);
    cyc("R2 write after lock", 1, 0, 6'h04, 32'h0);
    rd_chk("R2 reg1 kept", 6'h04);
    cyc("R9 idle", 0, 0, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule